// File: doc/BRIEF.md
# Configuration Mode Boot Sequencer

This block runs the start-up control sequence of a programmable device. When power-on reset is released, or when a qualified low pulse arrives on the active-low reconfigure input, it reads a 3-bit mode value. It turns that value into a bitstream source plan. It then waits for the ready line and starts a load through a request/response handshake with the chosen source. It reports completion on a done line that other agents can hold low.

Two mode values give a dual-boot plan. If the first source reports a failed load, the block tries the other source once. The flash, SPI, serial and parallel data paths are not part of this block. Each source is reached through one bit of a one-hot select vector, together with a shared start pulse and shared ok and fail responses.

The minimum width of a reconfigure pulse is given in picoseconds and converted to clock cycles when the block is elaborated. A shorter low glitch stalls the sequence only while the input is low and does not restart anything.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `rst_n` is low, `state_code` is 0 (sample), and `done_out`, `user_mode`, `src_start` and `src_sel` are all 0. The mode pins are sampled on the first clock edge after reset is released, so `state_code` is 1 (wait for ready) one cycle later.
- R2: The `src_sel` bit positions are: bit 0 internal flash, bit 1 external flash read as SPI master, bit 2 SPI slave, bit 3 serial, bit 4 parallel byte port. The mode map is: 000 internal; 001 SPI slave; 010 external flash; 101 serial; 111 parallel; 100 internal then external; 110 external then internal. `src_sel` is one-hot in states 1 and 2 and zero in every other state.
- R3: The mode pins are read only in state 0. A change on them at any other time has no effect on the source that is selected.
- R4: `src_start` is a single-cycle pulse. It is raised one cycle after state 1 sees `ready_in` and `reconfig_n` both high, and the state then becomes 2 (loading). While `ready_in` is low the block stays in state 1 and gives no start.
- R5: When a dual-boot mode's first source reports `src_fail`, the block returns to state 1 with the other source selected. A second failure, or any failure in a single-source mode, gives state 5 (failed) with `done_out` low.
- R6: On `src_ok` in state 2 the block enters state 3 and raises `done_out`. It stays in state 3, with `user_mode` low, while `done_hold_n` is low. It moves to state 4 (user mode, `user_mode` high) on the first edge that sees `done_hold_n` high.
- R7: `done_out` is low whenever `reconfig_n` or `ready_in` is low, in every state.
- R8: A low pulse on `reconfig_n` that lasts at least ceil(MIN_PULSE_PS / CLK_PERIOD_PS) cycles (5 at the defaults) restarts the sequence. Three cycles after the rising edge, `state_code` is the post-sample state for the current mode. A shorter pulse leaves the state unchanged.
- R9: While `reconfig_n` is low the state does not advance and no start pulse is given. The sequence resumes from where it was stopped when the line returns high.
- R10: Mode 011 is reserved. It gives state 6 (error) with `done_out` low and `src_sel` zero, and this holds until the next qualified reconfigure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| reconfig_n | input | 1 | Reconfigure request, active low |
| mode_pins | input | MODE_W (3) | Boot mode selection value |
| ready_in | input | 1 | Ready line; low stalls the start of a load |
| done_hold_n | input | 1 | External state of the done line; low delays user mode |
| src_ok | input | 1 | Selected source reports a completed load |
| src_fail | input | 1 | Selected source reports a failed load |
| src_sel | output | 5 | One-hot source select |
| src_start | output | 1 | One-cycle load start pulse |
| done_out | output | 1 | Done indication |
| user_mode | output | 1 | Device has entered user mode |
| state_code | output | 3 | Sequencer state: 0 sample, 1 wait ready, 2 load, 3 done hold, 4 user, 5 failed, 6 error |

## Verification
A wrong captured plan shows at the next start pulse: the one-hot select differs from the source expected for the mode. A broken fallback shows on the second start after a failure, which either selects the same source again or never arrives. A miscounted pulse-width qualifier shows exactly three cycles after the reconfigure input rises, as a restarted or unrestarted `state_code`, so the 4-, 5- and 6-cycle pulses expose an off-by-one. Gating errors on done appear in the same cycle that ready or reconfigure drops.

// File: rtl/cfg_boot_pkg.sv
`timescale 1ns/1ps
package cfg_boot_pkg;

   localparam int unsigned SRC_COUNT = 5;

   typedef enum logic [2:0] {
      ST_SAMPLE    = 3'd0,
      ST_WAIT_RDY  = 3'd1,
      ST_LOAD      = 3'd2,
      ST_DONE_HOLD = 3'd3,
      ST_USER      = 3'd4,
      ST_FAIL      = 3'd5,
      ST_ERROR     = 3'd6
   } boot_state_e;

   typedef enum logic [2:0] {
      SRC_INT    = 3'd0,
      SRC_XFLASH = 3'd1,
      SRC_SSPI   = 3'd2,
      SRC_SERIAL = 3'd3,
      SRC_PAR    = 3'd4
   } boot_src_e;

   typedef struct packed {
      logic      valid;
      logic      has_alt;
      boot_src_e first;
      boot_src_e second;
   } boot_plan_t;

endpackage

// File: rtl/cfg_mode_decode.sv
`timescale 1ns/1ps
module cfg_mode_decode
   import cfg_boot_pkg::*;
(
   input  logic [2:0]  mode_i,
   output boot_plan_t  plan_o
);

   always_comb begin
      plan_o = '{valid: 1'b1, has_alt: 1'b0, first: SRC_INT, second: SRC_INT};
      case (mode_i)
         3'b000: plan_o.first = SRC_INT;
         3'b001: plan_o.first = SRC_SSPI;
         3'b010: plan_o.first = SRC_XFLASH;
         3'b011: plan_o.valid = 1'b0;
         3'b100: begin
            plan_o.first   = SRC_INT;
            plan_o.second  = SRC_XFLASH;
            plan_o.has_alt = 1'b1;
         end
         3'b101: plan_o.first = SRC_SERIAL;
         3'b110: begin
            plan_o.first   = SRC_XFLASH;
            plan_o.second  = SRC_INT;
            plan_o.has_alt = 1'b1;
         end
         default: plan_o.first = SRC_PAR;
      endcase
   end

endmodule

// File: rtl/cfg_reconfig_qual.sv
`timescale 1ns/1ps
module cfg_reconfig_qual #(
   parameter int unsigned MIN_LOW = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reconfig_n,
   output logic trig_o
);

   localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);

   if (MIN_LOW < 1) begin : g_bad_width
      $error("cfg_reconfig_qual: MIN_LOW must be at least 1");
   end

   if (MIN_LOW == 1) begin : g_edge
      logic low_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            low_q  <= 1'b0;
            trig_o <= 1'b0;
         end else begin
            low_q  <= !reconfig_n;
            trig_o <= reconfig_n && low_q;
         end
      end
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            trig_o <= 1'b0;
         end else if (!reconfig_n) begin
            if (cnt_q != CNT_W'(MIN_LOW)) cnt_q <= cnt_q + 1'b1;
            trig_o <= 1'b0;
         end else begin
            trig_o <= (cnt_q == CNT_W'(MIN_LOW));
            cnt_q  <= '0;
         end
      end
   end

endmodule

// File: rtl/cfg_boot_fsm.sv
`timescale 1ns/1ps
module cfg_boot_fsm
   import cfg_boot_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trig_i,
   input  logic        reconfig_n,
   input  logic        ready_i,
   input  boot_plan_t  plan_i,
   input  logic        src_ok_i,
   input  logic        src_fail_i,
   input  logic        done_hold_n,
   output boot_state_e state_o,
   output boot_src_e   cur_src_o,
   output logic        start_o
);

   boot_state_e state_q;
   logic        has_alt_q;
   boot_src_e   first_q;
   boot_src_e   second_q;
   logic        on_alt_q;
   logic        start_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_SAMPLE;
         has_alt_q <= 1'b0;
         first_q   <= SRC_INT;
         second_q  <= SRC_INT;
         on_alt_q  <= 1'b0;
         start_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (trig_i) begin
            state_q  <= ST_SAMPLE;
            on_alt_q <= 1'b0;
         end else if (reconfig_n) begin
            case (state_q)
               ST_SAMPLE: begin
                  has_alt_q <= plan_i.has_alt;
                  first_q   <= plan_i.first;
                  second_q  <= plan_i.second;
                  on_alt_q  <= 1'b0;
                  state_q   <= plan_i.valid ? ST_WAIT_RDY : ST_ERROR;
               end
               ST_WAIT_RDY: begin
                  if (ready_i) begin
                     start_q <= 1'b1;
                     state_q <= ST_LOAD;
                  end
               end
               ST_LOAD: begin
                  if (src_ok_i) begin
                     state_q <= ST_DONE_HOLD;
                  end else if (src_fail_i) begin
                     if (has_alt_q && !on_alt_q) begin
                        on_alt_q <= 1'b1;
                        state_q  <= ST_WAIT_RDY;
                     end else begin
                        state_q <= ST_FAIL;
                     end
                  end
               end
               ST_DONE_HOLD: begin
                  if (done_hold_n) state_q <= ST_USER;
               end
               default: ;
            endcase
         end
      end
   end

   assign state_o   = state_q;
   assign cur_src_o = on_alt_q ? second_q : first_q;
   assign start_o   = start_q;

endmodule

// File: rtl/cfg_boot_seq.sv
`timescale 1ns/1ps
module cfg_boot_seq
   import cfg_boot_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned MIN_PULSE_PS  = 25000,
   parameter int unsigned MODE_W        = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reconfig_n,
   input  logic [MODE_W-1:0]    mode_pins,
   input  logic                 ready_in,
   input  logic                 done_hold_n,
   input  logic                 src_ok,
   input  logic                 src_fail,
   output logic [SRC_COUNT-1:0] src_sel,
   output logic                 src_start,
   output logic                 done_out,
   output logic                 user_mode,
   output logic [2:0]           state_code
);

   localparam int unsigned MIN_LOW_CYC = (MIN_PULSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

   if (MODE_W != 3) begin : g_bad_mode
      $error("cfg_boot_seq: MODE_W must be 3");
   end
   if (CLK_PERIOD_PS == 0 || MIN_PULSE_PS == 0) begin : g_bad_time
      $error("cfg_boot_seq: clock period and pulse width must be non-zero");
   end

   logic        trig;
   boot_plan_t  plan;
   boot_state_e state;
   boot_src_e   cur_src;
   logic        sel_live;

   cfg_reconfig_qual #(.MIN_LOW(MIN_LOW_CYC)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .reconfig_n (reconfig_n),
      .trig_o     (trig)
   );

   cfg_mode_decode u_decode (
      .mode_i (mode_pins[2:0]),
      .plan_o (plan)
   );

   cfg_boot_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig),
      .reconfig_n  (reconfig_n),
      .ready_i     (ready_in),
      .plan_i      (plan),
      .src_ok_i    (src_ok),
      .src_fail_i  (src_fail),
      .done_hold_n (done_hold_n),
      .state_o     (state),
      .cur_src_o   (cur_src),
      .start_o     (src_start)
   );

   assign sel_live = (state == ST_WAIT_RDY) || (state == ST_LOAD);

   for (genvar i = 0; i < SRC_COUNT; i++) begin : g_sel
      assign src_sel[i] = sel_live && (int'(cur_src) == i);
   end

   assign done_out   = ((state == ST_DONE_HOLD) || (state == ST_USER)) && reconfig_n && ready_in;
   assign user_mode  = (state == ST_USER);
   assign state_code = state;

endmodule

// File: rtl/cfg_boot_seq_chk.sv
`timescale 1ns/1ps
module cfg_boot_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reconfig_n,
   input logic       ready_in,
   input logic       done_hold_n,
   input logic [4:0] src_sel,
   input logic       src_start,
   input logic       done_out,
   input logic       user_mode,
   input logic [2:0] state_code
);

   p_sel_onehot0_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_sel));

   p_start_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      src_start |-> ($countones(src_sel) == 1));

   p_start_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      src_start |-> ($past(ready_in) && $past(reconfig_n)));

   p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      src_start |=> !src_start);

   p_user_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode) |-> $past(done_hold_n));

   p_done_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reconfig_n || !ready_in) |-> !done_out);

   p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!reconfig_n && $past(!reconfig_n)) |=> $stable(state_code));

   p_error_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd6) |-> (!done_out && (src_sel == 5'b0)));

endmodule

bind cfg_boot_seq cfg_boot_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reconfig_n  (reconfig_n),
   .ready_in    (ready_in),
   .done_hold_n (done_hold_n),
   .src_sel     (src_sel),
   .src_start   (src_start),
   .done_out    (done_out),
   .user_mode   (user_mode),
   .state_code  (state_code)
);

// File: tb/cfg_boot_seq_bench.sv
`timescale 1ns/1ps
module cfg_boot_seq_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reconfig_n = 1'b1;
   logic [2:0] mode_pins = 3'b000;
   logic       ready_in = 1'b0;
   logic       done_hold_n = 1'b0;
   logic       src_ok = 1'b0;
   logic       src_fail = 1'b0;
   logic [4:0] src_sel;
   logic       src_start;
   logic       done_out;
   logic       user_mode;
   logic [2:0] state_code;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   logic [4:0] exp_q[$];

   always #2.5 clk = ~clk;

   cfg_boot_seq u_cfg_boot_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .reconfig_n  (reconfig_n),
      .mode_pins   (mode_pins),
      .ready_in    (ready_in),
      .done_hold_n (done_hold_n),
      .src_ok      (src_ok),
      .src_fail    (src_fail),
      .src_sel     (src_sel),
      .src_start   (src_start),
      .done_out    (done_out),
      .user_mode   (user_mode),
      .state_code  (state_code)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [4:0] s);
      exp_q.push_back(s);
   endtask

   task automatic reconf(input int n);
      reconfig_n = 1'b0;
      step(n);
      reconfig_n = 1'b1;
   endtask

   task automatic restart(input logic [2:0] m, input int n);
      mode_pins = m;
      reconf(n);
      step(3);
   endtask

   task automatic pulse_ok();
      src_ok = 1'b1;
      step(1);
      src_ok = 1'b0;
   endtask

   task automatic pulse_fail();
      src_fail = 1'b1;
      step(1);
      src_fail = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // Scoreboard monitor: each start pulse must carry the next expected select
   always @(negedge clk) begin
      if (rst_n && src_start) begin
         logic [4:0] e;
         if (exp_q.size() == 0) begin
            check("R2", "unexpected start pulse", 1, 0);
         end else begin
            e = exp_q.pop_front();
            check("R2", "source select at start", int'(src_sel), int'(e));
         end
      end
   end

   initial begin
      #500000;
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL R1 watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [2:0] modes [4] = '{3'b001, 3'b010, 3'b101, 3'b111};
      logic [4:0] sels  [4] = '{5'b00100, 5'b00010, 5'b01000, 5'b10000};

      // R1 reset state
      step(2);
      check("R1", "state in reset", int'(state_code), 0);
      check("R1", "done in reset", int'(done_out), 0);
      check("R1", "user_mode in reset", int'(user_mode), 0);
      check("R1", "select in reset", int'(src_sel), 0);
      check("R1", "start in reset", int'(src_start), 0);

      // power-up with mode 000, ready low
      mode_pins = 3'b000;
      push(5'b00001);
      rst_n = 1'b1;
      step(1);
      check("R1", "state after first sample", int'(state_code), 1);
      check("R2", "mode 000 selects internal", int'(src_sel), 1);
      step(3);
      check("R4", "ready low keeps waiting", int'(state_code), 1);
      check("R4", "no start while ready low", int'(src_start), 0);

      // R3: change mode pins while waiting
      mode_pins = 3'b111;
      ready_in = 1'b1;
      step(1);
      check("R4", "start raised", int'(src_start), 1);
      check("R4", "loading state", int'(state_code), 2);
      check("R3", "select unchanged by late mode", int'(src_sel), 1);
      step(1);
      check("R4", "start is one cycle", int'(src_start), 0);

      // R6 success with done held low externally
      pulse_ok();
      check("R6", "done hold state", int'(state_code), 3);
      check("R6", "done high", int'(done_out), 1);
      check("R6", "user mode held off", int'(user_mode), 0);
      step(2);
      check("R6", "still held", int'(state_code), 3);
      done_hold_n = 1'b1;
      step(1);
      check("R6", "user state", int'(state_code), 4);
      check("R6", "user_mode high", int'(user_mode), 1);

      // R7 ready low forces done low
      ready_in = 1'b0;
      step(1);
      check("R7", "done low with ready low", int'(done_out), 0);
      check("R7", "user state kept", int'(user_mode), 1);
      ready_in = 1'b1;
      step(1);
      check("R7", "done back high", int'(done_out), 1);

      // R8 short glitch ignored, R7 done low during it
      reconfig_n = 1'b0;
      step(1);
      check("R7", "done low with reconfig low", int'(done_out), 0);
      step(1);
      reconfig_n = 1'b1;
      step(3);
      check("R8", "2-cycle glitch ignored", int'(state_code), 4);
      check("R8", "user_mode kept", int'(user_mode), 1);

      // R5 dual boot internal first, 6-cycle pulse
      done_hold_n = 1'b0;
      push(5'b00001);
      push(5'b00010);
      restart(3'b100, 6);
      check("R8", "restart after 6-cycle pulse", int'(state_code), 1);
      check("R8", "done low after restart", int'(done_out), 0);
      step(1);
      check("R5", "first load", int'(state_code), 2);
      pulse_fail();
      check("R5", "fallback to wait", int'(state_code), 1);
      check("R5", "fallback select external", int'(src_sel), 2);
      step(1);
      check("R5", "second load", int'(state_code), 2);
      pulse_fail();
      check("R5", "both failed", int'(state_code), 5);
      check("R5", "done low on failure", int'(done_out), 0);

      // mode 110, exact 5-cycle pulse
      push(5'b00010);
      push(5'b00001);
      restart(3'b110, 5);
      check("R8", "restart at minimum width", int'(state_code), 1);
      step(1);
      pulse_fail();
      check("R5", "110 fallback", int'(state_code), 1);
      step(1);
      pulse_ok();
      check("R5", "110 second source ok", int'(state_code), 3);
      check("R6", "done high in hold", int'(done_out), 1);

      // R8 one cycle short
      reconf(4);
      step(3);
      check("R8", "4-cycle pulse ignored", int'(state_code), 3);

      // single-source modes
      for (int i = 0; i < 4; i++) begin
         push(sels[i]);
         restart(modes[i], 5);
         check("R2", "single mode select", int'(src_sel), int'(sels[i]));
         step(1);
         check("R4", "single mode start", int'(src_start), 1);
         pulse_ok();
         check("R6", "single mode success", int'(state_code), 3);
      end

      // single-source failure
      push(5'b00001);
      restart(3'b000, 5);
      step(1);
      pulse_fail();
      check("R5", "single source failure", int'(state_code), 5);

      // R10 reserved mode
      restart(3'b011, 5);
      check("R10", "reserved mode error", int'(state_code), 6);
      check("R10", "error done low", int'(done_out), 0);
      check("R10", "error no select", int'(src_sel), 0);
      step(4);
      check("R10", "error persists", int'(state_code), 6);

      // R9 freeze while reconfig low
      ready_in = 1'b0;
      push(5'b00100);
      restart(3'b001, 5);
      check("R9", "waiting before freeze", int'(state_code), 1);
      reconfig_n = 1'b0;
      ready_in = 1'b1;
      step(3);
      check("R9", "frozen in wait", int'(state_code), 1);
      check("R9", "no start while frozen", int'(src_start), 0);
      reconfig_n = 1'b1;
      step(1);
      check("R9", "resumes with start", int'(src_start), 1);
      check("R9", "resumes loading", int'(state_code), 2);
      pulse_ok();
      check("R9", "load completes", int'(state_code), 3);

      check("R2", "scoreboard drained", exp_q.size(), 0);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule